// File: doc/BRIEF.md
# MESI Snoop Response Controller

This block works next to a small MESI-coherent data cache and answers every transaction it observes on a shared system bus. A snooped transaction arrives as a one-cycle strobe that carries a five-bit transfer type, a line address and a global flag. The block reads the line's state through a lookup port and then decides three things: whether to raise the retry and shared snoop-status outputs, what the line's new state is, and whether the dirty line must be cast out to memory. It reports the state change through a write port and the castout through a request and done pair.

Address-only operations (sync, TLB synchronise and TLB invalidate) are answered from pending-work flags that the core supplies and from the block's own castout tracker. A TLB invalidate that is accepted is passed on as a congruence-class index. The response is pipelined. The lookup happens one cycle after the strobe, and all outputs appear, registered, in the cycle after that. A state update still on its way to the cache is forwarded into the next lookup.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: Status, state-write, castout and invalidate outputs are asserted only in the second cycle after an accepted strobe, and are low in every other cycle including after reset.
- R2: A strobe with `snp_global` low is ignored: no status, no state write and no castout.
- R3: A read-intending-to-modify (type 5'b01101) that misses produces no output at all.
- R4: A read-intending-to-modify that hits a Shared (2'b01) or Exclusive (2'b10) line writes Invalid (2'b00), with no status.
- R5: A read-intending-to-modify that hits a Modified (2'b11) line asserts retry and shared, requests a castout of that line and writes Invalid.
- R6: The atomic variant (type 5'b11101) produces exactly the responses of R3 to R5.
- R7: A read-without-caching (type 5'b10101) that hits Modified asserts retry only, requests a castout and writes Exclusive. On a Shared or Exclusive hit, or on a miss, it does nothing. No snoop ever writes Modified.
- R8: A plain read (type 5'b00101) that hits Exclusive asserts shared and writes Shared. A hit on Shared asserts shared with no write. A hit on Modified asserts retry and shared, requests a castout and writes Shared. A miss does nothing.
- R9: A TLB-sync (type 5'b01001) asserts retry exactly when `tlbsync_dep` is high.
- R10: A TLB-invalidate (type 5'b01010) with `tlbi_pending` low pulses `tlbi_req` with `tlbi_class` equal to byte-address bits 19:12, and does not retry. With `tlbi_pending` high it asserts retry and raises no request.
- R11: A sync (type 5'b01000) asserts retry exactly when a castout is outstanding.
- R12: While a castout is outstanding (from its request until `co_done`), a hit on the castout line, or a Modified hit that would need a second castout, is answered with retry alone: no shared, no state write and no new castout.
- R13: A snoop that follows another to the same line in the next cycle decides on the state written by the first, not on the stale lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped address strobe |
| snp_global | input | 1 | Transaction requires coherence |
| snp_tt | input | 5 | Transfer type |
| snp_line | input | LINE_W (27) | Line address (byte address bits 31:5) |
| lk_line | output | LINE_W | Line being looked up |
| lk_hit | input | 1 | Lookup found the line |
| lk_state | input | 2 | State of the found line |
| st_wr_en | output | 1 | Write a new state |
| st_wr_line | output | LINE_W | Line to update |
| st_wr_state | output | 2 | New state |
| co_req | output | 1 | Castout request pulse |
| co_line | output | LINE_W | Line being cast out |
| co_done | input | 1 | Castout write finished |
| tlbi_pending | input | 1 | Core holds an unfinished TLB invalidate |
| tlbsync_dep | input | 1 | Work depending on invalidated translations is pending |
| tlbi_req | output | 1 | Congruence-class invalidate pulse |
| tlbi_class | output | 8 | Congruence-class index |
| rsp_retry | output | 1 | Retry snoop status |
| rsp_shared | output | 1 | Shared snoop status |

## Verification
The hardest situations to reach are the ones that span more than one transaction. One is a hit on a line whose castout has not yet finished. The other is a second snoop arriving one cycle behind the first to the same line, before the cache model has taken the first update. To reach the first, the bench holds back `co_done` after a Modified hit and sends more snoops to the same line and to a second Modified line. It also sends a sync, and only then completes the castout. To reach the second, it keeps the strobe high for two cycles in a row with a change of transfer type. Its cache model applies writes only at the clock edge, so only forwarding gives the right answer.

// File: rtl/snoop_resp_pkg.sv
package snoop_resp_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  localparam logic [4:0] TT_READ      = 5'b00101;
  localparam logic [4:0] TT_READ_NC   = 5'b10101;
  localparam logic [4:0] TT_RWITM     = 5'b01101;
  localparam logic [4:0] TT_RWITM_ATM = 5'b11101;
  localparam logic [4:0] TT_SYNC      = 5'b01000;
  localparam logic [4:0] TT_TLBSYNC   = 5'b01001;
  localparam logic [4:0] TT_TLBINV    = 5'b01010;

  typedef struct packed {
    logic  retry;
    logic  shared;
    logic  wr_en;
    mesi_t wr_state;
    logic  castout;
  } coh_act_t;

  function automatic logic tt_is_cache(input logic [4:0] tt);
    return (tt == TT_READ) || (tt == TT_READ_NC) ||
           (tt == TT_RWITM) || (tt == TT_RWITM_ATM);
  endfunction

  // Coherence action for a hit; state ST_I means no action.
  function automatic coh_act_t coh_decide(input logic [4:0] tt, input mesi_t st);
    coh_act_t a;
    a = '{retry: 1'b0, shared: 1'b0, wr_en: 1'b0, wr_state: ST_I, castout: 1'b0};
    unique case (tt)
      TT_RWITM, TT_RWITM_ATM: begin
        if (st == ST_S || st == ST_E) begin
          a.wr_en = 1'b1;
          a.wr_state = ST_I;
        end else if (st == ST_M) begin
          a.retry = 1'b1;
          a.shared = 1'b1;
          a.castout = 1'b1;
          a.wr_en = 1'b1;
          a.wr_state = ST_I;
        end
      end
      TT_READ: begin
        if (st == ST_S) begin
          a.shared = 1'b1;
        end else if (st == ST_E) begin
          a.shared = 1'b1;
          a.wr_en = 1'b1;
          a.wr_state = ST_S;
        end else if (st == ST_M) begin
          a.retry = 1'b1;
          a.shared = 1'b1;
          a.castout = 1'b1;
          a.wr_en = 1'b1;
          a.wr_state = ST_S;
        end
      end
      TT_READ_NC: begin
        if (st == ST_M) begin
          a.retry = 1'b1;
          a.castout = 1'b1;
          a.wr_en = 1'b1;
          a.wr_state = ST_E;
        end
      end
      default: ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/snoop_coh_decode.sv
module snoop_coh_decode
  import snoop_resp_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic [4:0]        tt,
  input  mesi_t             state,
  input  logic [LINE_W-1:0] line,
  input  logic              co_busy,
  input  logic [LINE_W-1:0] co_line,
  output coh_act_t          act,
  output logic              blocked
);
  coh_act_t base;
  logic     hit;
  logic     hit_castout_line;
  logic     second_castout;

  assign hit              = (state != ST_I);
  assign base             = coh_decide(tt, state);
  assign hit_castout_line = hit && co_busy && (line == co_line);
  assign second_castout   = base.castout && co_busy;
  assign blocked          = hit_castout_line || second_castout;

  always_comb begin
    if (blocked) begin
      act = '{retry: 1'b1, shared: 1'b0, wr_en: 1'b0, wr_state: ST_I, castout: 1'b0};
    end else begin
      act = base;
    end
  end
endmodule

// File: rtl/snoop_addr_only.sv
module snoop_addr_only
  import snoop_resp_pkg::*;
#(
  parameter int CLASS_W = 8
) (
  input  logic [4:0]         tt,
  input  logic [CLASS_W-1:0] class_in,
  input  logic               co_busy,
  input  logic               tlbi_pending,
  input  logic               tlbsync_dep,
  output logic               retry,
  output logic               tlbi_go,
  output logic [CLASS_W-1:0] tlbi_class
);
  always_comb begin
    retry   = 1'b0;
    tlbi_go = 1'b0;
    unique case (tt)
      TT_SYNC:    retry = co_busy;
      TT_TLBSYNC: retry = tlbsync_dep;
      TT_TLBINV: begin
        retry   = tlbi_pending;
        tlbi_go = !tlbi_pending;
      end
      default: ;
    endcase
  end

  assign tlbi_class = class_in;
endmodule

// File: rtl/snoop_castout_track.sv
module snoop_castout_track #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [LINE_W-1:0] launch_line,
  input  logic              done,
  output logic              busy,
  output logic [LINE_W-1:0] line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      line <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      line <= launch_line;
    end else if (done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
  import snoop_resp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 5,
  parameter int CLASS_LO = 12,
  parameter int CLASS_W  = 8,
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int CLS_POS = CLASS_LO - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  input  logic               snp_global,
  input  logic [4:0]         snp_tt,
  input  logic [LINE_W-1:0]  snp_line,
  output logic [LINE_W-1:0]  lk_line,
  input  logic               lk_hit,
  input  logic [1:0]         lk_state,
  output logic               st_wr_en,
  output logic [LINE_W-1:0]  st_wr_line,
  output logic [1:0]         st_wr_state,
  output logic               co_req,
  output logic [LINE_W-1:0]  co_line,
  input  logic               co_done,
  input  logic               tlbi_pending,
  input  logic               tlbsync_dep,
  output logic               tlbi_req,
  output logic [CLASS_W-1:0] tlbi_class,
  output logic               rsp_retry,
  output logic               rsp_shared
);
  // Stage 1: accepted snoop, lookup in flight
  logic               s1_valid;
  logic [4:0]         s1_tt;
  logic [LINE_W-1:0]  s1_line;
  logic [CLASS_W-1:0] s1_class;
  logic               accept;

  assign accept = snp_valid && snp_global;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tt    <= '0;
      s1_line  <= '0;
      s1_class <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_tt    <= snp_tt;
        s1_line  <= snp_line;
        s1_class <= snp_line[CLS_POS +: CLASS_W];
      end
    end
  end

  assign lk_line = s1_line;

  // Forward a state write that the cache has not yet taken
  logic  fwd_hit;
  mesi_t eff_state;
  assign fwd_hit   = st_wr_en && (st_wr_line == s1_line);
  assign eff_state = fwd_hit ? mesi_t'(st_wr_state)
                             : (lk_hit ? mesi_t'(lk_state) : ST_I);

  logic              co_busy;
  logic [LINE_W-1:0] co_held_line;
  coh_act_t          act;
  logic              coh_blocked;
  logic              s1_cache;

  assign s1_cache = tt_is_cache(s1_tt);

  snoop_coh_decode #(.LINE_W(LINE_W)) u_decode (
    .tt      (s1_tt),
    .state   (eff_state),
    .line    (s1_line),
    .co_busy (co_busy),
    .co_line (co_held_line),
    .act     (act),
    .blocked (coh_blocked)
  );

  logic               ao_retry;
  logic               ao_tlbi;
  logic [CLASS_W-1:0] ao_class;

  snoop_addr_only #(.CLASS_W(CLASS_W)) u_addr_only (
    .tt           (s1_tt),
    .class_in     (s1_class),
    .co_busy      (co_busy),
    .tlbi_pending (tlbi_pending),
    .tlbsync_dep  (tlbsync_dep),
    .retry        (ao_retry),
    .tlbi_go      (ao_tlbi),
    .tlbi_class   (ao_class)
  );

  logic co_launch;
  assign co_launch = s1_valid && s1_cache && act.castout;

  snoop_castout_track #(.LINE_W(LINE_W)) u_castout (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (co_launch),
    .launch_line (s1_line),
    .done        (co_done),
    .busy        (co_busy),
    .line        (co_held_line)
  );

  assign co_line = co_held_line;

  // Stage 2: registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_retry   <= 1'b0;
      rsp_shared  <= 1'b0;
      st_wr_en    <= 1'b0;
      st_wr_line  <= '0;
      st_wr_state <= ST_I;
      co_req      <= 1'b0;
      tlbi_req    <= 1'b0;
      tlbi_class  <= '0;
    end else begin
      rsp_retry   <= s1_valid && (s1_cache ? act.retry : ao_retry);
      rsp_shared  <= s1_valid && s1_cache && act.shared;
      st_wr_en    <= s1_valid && s1_cache && act.wr_en;
      st_wr_line  <= s1_line;
      st_wr_state <= act.wr_state;
      co_req      <= co_launch;
      tlbi_req    <= s1_valid && !s1_cache && ao_tlbi;
      tlbi_class  <= ao_class;
    end
  end
endmodule

// File: rtl/snoop_resp_ctrl_chk.sv
module snoop_resp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic       snp_global,
  input logic       rsp_retry,
  input logic       rsp_shared,
  input logic       st_wr_en,
  input logic [1:0] st_wr_state,
  input logic       co_req,
  input logic       co_busy,
  input logic       tlbi_req
);
  logic slot1;
  logic slot2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot1 <= 1'b0;
      slot2 <= 1'b0;
    end else begin
      slot1 <= snp_valid && snp_global;
      slot2 <= slot1;
    end
  end

  // R1, R2: any response sits in the second cycle after an accepted strobe
  a_r1_response_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_retry || rsp_shared || st_wr_en || co_req || tlbi_req) |-> slot2);

  // R5: a castout always comes with retry and an outstanding tracker
  a_r5_castout_retries: assert property (@(posedge clk) disable iff (!rst_n)
    co_req |-> (rsp_retry && co_busy));

  // R12: no second castout while one is outstanding
  a_r12_single_castout: assert property (@(posedge clk) disable iff (!rst_n)
    co_req |=> !co_req);

  // R10: an accepted invalidate carries no snoop status
  a_r10_tlbi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tlbi_req |-> (!rsp_retry && !rsp_shared && !st_wr_en));

  // R7: a snoop never writes Modified
  a_r7_never_modified: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> (st_wr_state != 2'b11));
endmodule

bind snoop_resp_ctrl snoop_resp_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_valid   (snp_valid),
  .snp_global  (snp_global),
  .rsp_retry   (rsp_retry),
  .rsp_shared  (rsp_shared),
  .st_wr_en    (st_wr_en),
  .st_wr_state (st_wr_state),
  .co_req      (co_req),
  .co_busy     (co_busy),
  .tlbi_req    (tlbi_req)
);

// File: tb/snoop_resp_ctrl_bench.sv
`timescale 1ns/1ps
module snoop_resp_ctrl_bench;
  localparam int LW = 27;
  localparam logic [4:0] T_READ = 5'b00101, T_RNC = 5'b10101, T_RWITM = 5'b01101,
                         T_ATOM = 5'b11101, T_SYNC = 5'b01000, T_TSYNC = 5'b01001,
                         T_TINV = 5'b01010;
  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
  localparam logic [31:0] ADDR_A = 32'h00AB3060;   // index 3, bits 19:12 = 8'hB3
  localparam logic [31:0] ADDR_X = 32'h01AB3060;   // same index, other tag
  localparam logic [31:0] ADDR_B = 32'h00AB30A0;   // index 5
  localparam logic [31:0] ADDR_C = 32'h00AB30C0;   // index 6
  localparam logic [LW-1:0] LINE_A = ADDR_A[31:5];
  localparam logic [LW-1:0] LINE_X = ADDR_X[31:5];
  localparam logic [LW-1:0] LINE_B = ADDR_B[31:5];
  localparam logic [LW-1:0] LINE_C = ADDR_C[31:5];

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic snp_valid = 1'b0, snp_global = 1'b0, co_done = 1'b0;
  logic tlbi_pending = 1'b0, tlbsync_dep = 1'b0;
  logic [4:0] snp_tt = '0;
  logic [LW-1:0] snp_line = '0;
  logic [LW-1:0] lk_line, st_wr_line, co_line;
  logic lk_hit, st_wr_en, co_req, tlbi_req, rsp_retry, rsp_shared;
  logic [1:0] lk_state, st_wr_state;
  logic [7:0] tlbi_class;

  snoop_resp_ctrl u_snoop_resp_ctrl (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_global(snp_global),
    .snp_tt(snp_tt), .snp_line(snp_line), .lk_line(lk_line), .lk_hit(lk_hit),
    .lk_state(lk_state), .st_wr_en(st_wr_en), .st_wr_line(st_wr_line),
    .st_wr_state(st_wr_state), .co_req(co_req), .co_line(co_line), .co_done(co_done),
    .tlbi_pending(tlbi_pending), .tlbsync_dep(tlbsync_dep), .tlbi_req(tlbi_req),
    .tlbi_class(tlbi_class), .rsp_retry(rsp_retry), .rsp_shared(rsp_shared));

  // Cache tag/state model: 16 entries, writes taken at the clock edge
  logic [LW-1:0] m_line [16];
  logic [1:0]    m_st   [16];
  logic          pre_en = 1'b0;
  logic [LW-1:0] pre_ln = '0;
  logic [1:0]    pre_st = '0;
  assign lk_hit   = (m_st[lk_line[3:0]] != I) && (m_line[lk_line[3:0]] == lk_line);
  assign lk_state = m_st[lk_line[3:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_st[k] <= I; m_line[k] <= '0; end
    end else if (pre_en) begin
      m_line[pre_ln[3:0]] <= pre_ln;
      m_st[pre_ln[3:0]]   <= pre_st;
    end else if (st_wr_en) begin
      m_st[st_wr_line[3:0]] <= st_wr_state;
    end
  end

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic o_retry, o_shared, o_wr, o_co, o_tlbi;
  logic [1:0] o_wst;
  logic [LW-1:0] o_coline;
  logic [7:0] o_class;

  task automatic capture();
    o_retry = rsp_retry; o_shared = rsp_shared; o_wr = st_wr_en; o_wst = st_wr_state;
    o_co = co_req; o_tlbi = tlbi_req; o_coline = co_line; o_class = tlbi_class;
  endtask

  task automatic preset(input logic [LW-1:0] ln, input logic [1:0] st);
    @(negedge clk); pre_en = 1'b1; pre_ln = ln; pre_st = st;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic snoop(input logic [4:0] tt, input logic [LW-1:0] ln, input logic gl);
    @(negedge clk); snp_valid = 1'b1; snp_tt = tt; snp_line = ln; snp_global = gl;
    @(negedge clk); snp_valid = 1'b0; snp_global = 1'b0;
    // R1: nothing in the first cycle after the strobe
    chk("R1 quiet first cycle", {rsp_retry, rsp_shared, st_wr_en, co_req, tlbi_req}, 0);
    @(negedge clk); capture();
  endtask

  task automatic finish_castout();
    @(negedge clk); co_done = 1'b1;
    @(negedge clk); co_done = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0] rq; logic [4:0] tt; logic gl; logic [1:0] pre; logic hit;
    logic tp; logic sd; logic er; logic es; logic ew; logic [1:0] ews; logic ec; logic et;
  } vec_t;

  // rq tt gl pre hit tp sd | retry shared wr wst castout tlbi
  localparam vec_t VEC [17] = '{
    '{4'd3,  T_RWITM, 1'b1, S, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R3 miss
    '{4'd4,  T_RWITM, 1'b1, S, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, I, 1'b0, 1'b0}, // R4
    '{4'd4,  T_RWITM, 1'b1, E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, I, 1'b0, 1'b0}, // R4
    '{4'd5,  T_RWITM, 1'b1, M, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, I, 1'b1, 1'b0}, // R5
    '{4'd6,  T_ATOM,  1'b1, E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, I, 1'b0, 1'b0}, // R6
    '{4'd6,  T_ATOM,  1'b1, M, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, I, 1'b1, 1'b0}, // R6
    '{4'd7,  T_RNC,   1'b1, M, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, E, 1'b1, 1'b0}, // R7
    '{4'd7,  T_RNC,   1'b1, S, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R7
    '{4'd8,  T_READ,  1'b1, E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, S, 1'b0, 1'b0}, // R8
    '{4'd8,  T_READ,  1'b1, M, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, S, 1'b1, 1'b0}, // R8
    '{4'd8,  T_READ,  1'b1, S, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, I, 1'b0, 1'b0}, // R8
    '{4'd2,  T_RWITM, 1'b0, M, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R2
    '{4'd9,  T_TSYNC, 1'b1, I, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R9
    '{4'd9,  T_TSYNC, 1'b1, I, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R9
    '{4'd10, T_TINV,  1'b1, I, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b1}, // R10
    '{4'd10, T_TINV,  1'b1, I, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, I, 1'b0, 1'b0}, // R10
    '{4'd11, T_SYNC,  1'b1, I, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, I, 1'b0, 1'b0}  // R11
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {rsp_retry, rsp_shared, st_wr_en, co_req, tlbi_req}, 0);

    for (int i = 0; i < 17; i++) begin
      vec_t v;
      string t;
      v = VEC[i];
      preset(LINE_A, v.pre);
      tlbi_pending = v.tp; tlbsync_dep = v.sd;
      snoop(v.tt, v.hit ? LINE_A : LINE_X, v.gl);
      t = $sformatf("R%0d vec%0d", v.rq, i);
      chk({t, " retry"},  o_retry,  v.er);
      chk({t, " shared"}, o_shared, v.es);
      chk({t, " wr_en"},  o_wr,     v.ew);
      if (v.ew) chk({t, " wr_state"}, o_wst, v.ews);
      chk({t, " castout"}, o_co, v.ec);
      chk({t, " tlbi"},    o_tlbi, v.et);
      if (v.et) chk({t, " class"}, o_class, 8'hB3);   // R10 address bits 19:12
      if (o_co) begin
        chk({t, " castout line"}, o_coline, LINE_A);
        finish_castout();
      end
      tlbi_pending = 1'b0; tlbsync_dep = 1'b0;
    end

    // R12 / R11: behaviour while a castout is outstanding
    preset(LINE_A, M);
    snoop(T_RNC, LINE_A, 1'b1);
    chk("R7 castout launched", o_co, 1'b1);
    snoop(T_READ, LINE_A, 1'b1);               // line A now E, castout open
    chk("R12 same-line retry", o_retry, 1'b1);
    chk("R12 same-line no shared", o_shared, 1'b0);
    chk("R12 same-line no write", o_wr, 1'b0);
    snoop(T_SYNC, LINE_A, 1'b1);
    chk("R11 sync retried while busy", o_retry, 1'b1);
    preset(LINE_B, M);
    snoop(T_RWITM, LINE_B, 1'b1);
    chk("R12 second castout retried", o_retry, 1'b1);
    chk("R12 second castout blocked", o_co, 1'b0);
    chk("R12 second line no write", o_wr, 1'b0);
    chk("R12 second line no shared", o_shared, 1'b0);
    finish_castout();
    snoop(T_READ, LINE_A, 1'b1);
    chk("R12 after done no retry", o_retry, 1'b0);
    chk("R12 after done shared", o_shared, 1'b1);
    chk("R12 after done write S", {o_wr, o_wst}, {1'b1, S});
    snoop(T_SYNC, LINE_A, 1'b1);
    chk("R11 sync free after done", o_retry, 1'b0);

    // R13: back-to-back snoops to one line
    preset(LINE_C, E);
    @(negedge clk); snp_valid = 1'b1; snp_global = 1'b1; snp_tt = T_RWITM; snp_line = LINE_C;
    @(negedge clk); snp_tt = T_READ;
    @(negedge clk); snp_valid = 1'b0; snp_global = 1'b0;
    chk("R13 first writes I", {st_wr_en, st_wr_state}, {1'b1, I});
    chk("R13 first no shared", rsp_shared, 1'b0);
    @(negedge clk);
    chk("R13 second sees I: no shared", rsp_shared, 1'b0);
    chk("R13 second sees I: no write", st_wr_en, 1'b0);
    chk("R13 second no retry", rsp_retry, 1'b0);
    @(negedge clk);
    chk("R1 idle after burst", {rsp_retry, rsp_shared, st_wr_en, co_req, tlbi_req}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule